// File: doc/BRIEF.md
# Two-Slot Audio DMA Request Generator

This block raises direct-memory-access request lines for a two-slot audio serial port. Each slot has a receive data holding register and a transmit data holding register. The receive side asks for service when its holding register is full. The transmit side asks for service when its holding register is empty. A 16-bit control word enables each request through a mask field per direction. A separate assignment bit per slot and direction must also be set, so an unassigned slot never produces a request, whatever its mask bit says.

The control word is written and read through a simple register port. The requests are registered, so each one reflects the inputs seen at the previous clock edge. When the DMA controller reads a receive register or writes a transmit register, it pulses the matching service strobe. The request for that slot is then low in the following cycle, even if the full or empty flag has not yet updated. Only slots 0 and 1 exist. Mask bits for slots 2 and 3 can be stored but never raise a request.

Top module: `audio_dma_req`

## Requirements
- R1: Control word bits 3:0 form the transmit mask and bits 7:4 the receive mask. Bit 0 or bit 4 belongs to slot 0, and bit 1 or bit 5 belongs to slot 1. A write takes effect on the clock edge where `ctl_wr_en` is high, and the new value is used from the next edge onward.
- R2: After reset the control word reads 0x0000 and all four request outputs are low.
- R3: `rx_req[n]` is high one cycle after an edge at which all of the following hold: receive mask bit n is set, `rx_assign[n]` is high, `rx_full[n]` is high, and `rx_read[n]` is low.
- R4: `tx_req[n]` is high one cycle after an edge at which all of the following hold: transmit mask bit n is set, `tx_assign[n]` is high, `tx_empty[n]` is high, and `tx_write[n]` is low.
- R5: While a slot's assignment bit for a direction is low, that slot's request in that direction is low in the next cycle, regardless of its mask bit.
- R6: Mask bits for slots 2 and 3 (control bits 2, 3, 6 and 7) never cause any request, even with every flag and assignment bit high.
- R7: With both mask bits of a direction set, each slot's condition raises only that slot's own request, independently of the other slot.
- R8: A high `rx_read[n]` or `tx_write[n]` at an edge forces the matching request low in the following cycle.
- R9: Control bits 15:13 always read as zero and ignore writes. Bits 12:0 read back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 16 | Control word write value |
| ctl_rd_data | output | 16 | Control word read value |
| rx_assign | input | 2 | Per-slot receive assignment bits |
| tx_assign | input | 2 | Per-slot transmit assignment bits |
| rx_full | input | 2 | Receive holding register full flags |
| tx_empty | input | 2 | Transmit holding register empty flags |
| rx_read | input | 2 | Receive register serviced strobe |
| tx_write | input | 2 | Transmit register serviced strobe |
| rx_req | output | 2 | Receive DMA request per slot |
| tx_req | output | 2 | Transmit DMA request per slot |

## Verification
A corrupted mask bit in the stored control word shows up at once on the read port. It also shows up one cycle later as a request that is missing or unexpected. A request flop that fails to clear after a service strobe appears as a stuck-high output in the very next cycle. The bench compares every output on every cycle, under random flags and strobes, so any such fault is caught within one cycle of the stimulus that exposes it.

// File: rtl/audio_dma_req.sv
module audio_dma_req #(
  parameter int SLOTS  = 2,
  parameter int MASK_W = 4,
  parameter int CTL_W  = 16,
  parameter int RSV_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr_en,
  input  logic [CTL_W-1:0]   ctl_wr_data,
  output logic [CTL_W-1:0]   ctl_rd_data,
  input  logic [SLOTS-1:0]   rx_assign,
  input  logic [SLOTS-1:0]   tx_assign,
  input  logic [SLOTS-1:0]   rx_full,
  input  logic [SLOTS-1:0]   tx_empty,
  input  logic [SLOTS-1:0]   rx_read,
  input  logic [SLOTS-1:0]   tx_write,
  output logic [SLOTS-1:0]   rx_req,
  output logic [SLOTS-1:0]   tx_req
);
  localparam int STORE_W = CTL_W - RSV_W;
  localparam int TX_LO   = 0;
  localparam int RX_LO   = MASK_W;

  logic [STORE_W-1:0] ctl_q;
  logic [SLOTS-1:0]   rx_en, tx_en;
  logic [SLOTS-1:0]   rx_cond, tx_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctl_q <= '0;
    else if (ctl_wr_en) ctl_q <= ctl_wr_data[STORE_W-1:0];
  end

  assign ctl_rd_data = {{RSV_W{1'b0}}, ctl_q};
  assign rx_en = ctl_q[RX_LO +: SLOTS];
  assign tx_en = ctl_q[TX_LO +: SLOTS];

  assign rx_cond = rx_en & rx_assign & rx_full  & ~rx_read;
  assign tx_cond = tx_en & tx_assign & tx_empty & ~tx_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_req <= '0;
      tx_req <= '0;
    end else begin
      rx_req <= rx_cond;
      tx_req <= tx_cond;
    end
  end

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_chk
      AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req[g] |-> $past(ctl_q[RX_LO+g] && rx_assign[g] && rx_full[g])); // R3
      AST_TX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req[g] |-> $past(ctl_q[TX_LO+g] && tx_assign[g] && tx_empty[g])); // R4
      AST_RX_UNASSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_assign[g] |=> !rx_req[g]); // R5
      AST_TX_UNASSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_assign[g] |=> !tx_req[g]); // R5
      AST_RX_SERVICED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_read[g] |=> !rx_req[g]); // R8
      AST_TX_SERVICED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_write[g] |=> !tx_req[g]); // R8
    end
  endgenerate

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_en |=> ctl_rd_data[CTL_W-1:STORE_W] == '0); // R9
endmodule

// File: tb/audio_dma_req_tb.sv
module audio_dma_req_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr_en = 1'b0;
  logic [15:0] ctl_wr_data = '0;
  logic [15:0] ctl_rd_data;
  logic [1:0] rx_assign = '0, tx_assign = '0, rx_full = '0, tx_empty = '0;
  logic [1:0] rx_read = '0, tx_write = '0;
  logic [1:0] rx_req, tx_req;

  int checks = 0;
  int fails = 0;
  logic [15:0] ctl_m = '0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  audio_dma_req dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data), .rx_assign(rx_assign), .tx_assign(tx_assign),
    .rx_full(rx_full), .tx_empty(tx_empty), .rx_read(rx_read), .tx_write(tx_write),
    .rx_req(rx_req), .tx_req(tx_req));

  function automatic logic [1:0] exp_req(input logic [3:0] mask, input logic [1:0] asg,
                                         input logic [1:0] flag, input logic [1:0] svc);
    logic [1:0] r;
    for (int i = 0; i < 2; i++) r[i] = mask[i] & asg[i] & flag[i] & ~svc[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [15:0] wd, input logic [1:0] ra,
                     input logic [1:0] ta, input logic [1:0] rf, input logic [1:0] te,
                     input logic [1:0] rr, input logic [1:0] tw, input string tag);
    logic [1:0] erx, etx;
    ctl_wr_en = we; ctl_wr_data = wd; rx_assign = ra; tx_assign = ta;
    rx_full = rf; tx_empty = te; rx_read = rr; tx_write = tw;
    erx = exp_req(ctl_m[7:4], ra, rf, rr);
    etx = exp_req(ctl_m[3:0], ta, te, tw);
    @(posedge clk);
    if (we) ctl_m = wd & 16'h1FFF;
    @(negedge clk);
    chk({tag, " rx_req"}, {14'd0, rx_req}, {14'd0, erx});
    chk({tag, " tx_req"}, {14'd0, tx_req}, {14'd0, etx});
    chk({tag, " ctl_rd_data"}, ctl_rd_data, ctl_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    s = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    chk("R2 reset rx_req", {14'd0, rx_req}, 16'd0);
    chk("R2 reset tx_req", {14'd0, tx_req}, 16'd0);
    chk("R2 reset ctl", ctl_rd_data, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(0, 0, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R2 all flags ctl zero");
    // R1: receive mask slot 0 only (bit 4), then slot 1 transmit (bit 1)
    cyc(1, 16'h0010, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R1 write rx0");
    cyc(0, 0, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R1 rx0 only");
    cyc(1, 16'h0002, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R1 write tx1");
    cyc(0, 0, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R1 R4 tx1 only");
    // R6: unsupported mask bits
    cyc(1, 16'h00CC, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R6 write high masks");
    cyc(0, 0, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R6 no request");
    // R7: both slots independent
    cyc(1, 16'h0033, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R7 write both");
    cyc(0, 0, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R7 both high");
    cyc(0, 0, 2'b11, 2'b11, 2'b10, 2'b01, 0, 0, "R7 R3 R4 split slots");
    cyc(0, 0, 2'b11, 2'b11, 2'b00, 2'b00, 0, 0, "R3 R4 flags polarity idle");
    // R5: assignment clear overrides mask
    cyc(0, 0, 2'b01, 2'b10, 2'b11, 2'b11, 0, 0, "R5 one unassigned");
    cyc(0, 0, 2'b00, 2'b00, 2'b11, 2'b11, 0, 0, "R5 none assigned");
    // R8: service strobes
    cyc(0, 0, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R8 prime");
    cyc(0, 0, 2'b11, 2'b11, 2'b11, 2'b11, 2'b01, 2'b10, "R8 serviced drop");
    cyc(0, 0, 2'b11, 2'b11, 2'b11, 2'b11, 0, 0, "R8 reassert");
    // R9: reserved bits
    cyc(1, 16'hFFFF, 0, 0, 0, 0, 0, 0, "R9 write all ones");
    cyc(1, 16'hA5A5, 0, 0, 0, 0, 0, 0, "R9 pattern");
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[31:28] == 4'd0, r[15:0], r[17:16], r[19:18], r[21:20], r[23:22],
          r[25:24] & {2{r[26]}}, r[28:27] & {2{r[29]}}, "R3 R4 R5 R8 R9 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule